// File: doc/BRIEF.md
# Dual-Issue Pairing Legality Checker

This issue-stage block receives two decoded vector operations per transfer, one for an X slot and one for a Y slot, and decides whether both may go to the execution stage in the same cycle. The pair shares a register file split into four banks and a small set of scalar read ports. The pair is granted dual issue only when five conditions hold. Sources in the same operand position must sit in different banks. The two destinations must land in different bank pairs. The scalar inputs, counting immediates, must fit a budget of two. Each operation class must be allowed in its slot. The Y operation must not depend on the X operation.

When the pair is rejected, the block splits it: X leaves alone in one beat and Y alone in the following beat. The block accepts nothing while the X-only beat is held. The grant and both descriptors are registered, and a valid/ready handshake on each side controls the flow. A stalled consumer freezes the beat on offer.

The control is a four-state machine:
- `ST_EMPTY`: nothing is on offer.
- `ST_PAIR`: a dual beat is on offer.
- `ST_XONLY`: the first half of a split is on offer.
- `ST_YONLY`: the second half of a split is on offer.

Its transitions are:
- From `ST_EMPTY`, an accepted pair moves to `ST_PAIR` if it is legal and to `ST_XONLY` if it is not.
- From `ST_XONLY`, a consumed beat moves to `ST_YONLY`.
- From `ST_PAIR` or `ST_YONLY`, a consumed beat moves to `ST_PAIR` or `ST_XONLY` when a new pair is accepted in the same cycle, and to `ST_EMPTY` when none is.
- In any state with a beat on offer, an unconsumed beat stays where it is.

Top module: `dual_issue_pairer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A descriptor is packed from the least significant bit upward, with the default register width of 6:
  - position-0 source kind in bits [1:0] and its register in bits [7:2];
  - position-1 source kind in bits [9:8] and its register in bits [15:10];
  - destination in bits [21:16];
  - class in bits [24:22].
  
  The source kind codes are 0 unused, 1 vector register, 2 scalar register and 3 immediate. A register's bank is its number modulo 4. If the X and Y sources in the same position are both vector registers in the same bank, the pair is split. Sources in different positions never conflict.
- R3: If both destinations have the same parity, the pair is split. Even destinations use banks {0,2} and odd destinations use banks {1,3}.
- R4: The four source positions of the pair are counted together. Each one of kind 2 or kind 3 counts as one scalar input. A count above 2 splits the pair, and a count of 2 or less does not.
- R5: Classes 0 to 3 may go in either slot, class 4 only in X, and class 5 only in Y. Classes 6 and 7 are never dual-issued. A pair with a class outside its slot's allowed set is split.
- R6: The pair is split when the Y destination equals the register number of an X source of kind 1, or when both destinations are equal.
- R7: A pair that meets R2 to R6 appears one cycle after acceptance as a single beat. In that beat `out_dual`, `out_x_en` and `out_y_en` are 1, and `out_x` and `out_y` equal the accepted descriptors.
- R8: A split pair first offers `out_x` = X with `out_x_en`=1, `out_y_en`=0 and `out_dual`=0. `in_ready` stays 0 throughout that beat. After that beat is consumed, the block offers `out_y` = Y with `out_y_en`=1 and `out_x_en`=0.
- R9: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pair is presented |
| in_ready | output | 1 | The block accepts the presented pair this cycle |
| in_x | input | DW (25) | X-slot descriptor |
| in_y | input | DW (25) | Y-slot descriptor |
| out_valid | output | 1 | A beat is offered to execution |
| out_ready | input | 1 | Execution takes the offered beat |
| out_dual | output | 1 | The beat carries both operations |
| out_x_en | output | 1 | `out_x` carries an operation in this beat |
| out_y_en | output | 1 | `out_y` carries an operation in this beat |
| out_x | output | DW (25) | Registered X descriptor |
| out_y | output | DW (25) | Registered Y descriptor |

## Verification
The assertions assume that `in_x` and `in_y` are well-formed packed descriptors. They also assume that `in_valid` and the descriptors stay steady during the cycle in which they are sampled. They do not assume the producer holds a pair after a refusal, because a refused pair is simply re-presented. The stimulus keeps within these assumptions by changing inputs only on falling edges, and by presenting each pair only when the machine is empty or finishing a beat.

The stimulus covers several kinds of pair:
- exhaustive bank and parity grids;
- every class combination;
- every mix of the four source kinds;
- a long run of arbitrary pairs built with narrow register numbers, so that conflicts and dependencies occur often.

Stalls are inserted into both dual and split sequences.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_VREG = 2'd1,
        SRC_SREG = 2'd2,
        SRC_IMM  = 2'd3
    } src_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PAIR  = 2'd1,
        ST_XONLY = 2'd2,
        ST_YONLY = 2'd3
    } issue_st_e;

    localparam int KIND_W = 2;
    localparam int BANK_W = 2;

endpackage

// File: rtl/dip_bank_check.sv
module dip_bank_check
    import dip_pkg::*;
#(
    parameter int REG_W = 6,
    parameter int NSRC  = 2
) (
    input  logic [NSRC*KIND_W-1:0] x_kind,
    input  logic [NSRC*REG_W-1:0]  x_src,
    input  logic [NSRC*KIND_W-1:0] y_kind,
    input  logic [NSRC*REG_W-1:0]  y_src,
    input  logic [REG_W-1:0]       x_dst,
    input  logic [REG_W-1:0]       y_dst,
    output logic                   bank_conf,
    output logic                   dst_clash
);

    logic [NSRC-1:0] pos_conf;

    // Each operand position has its own bank-conflict comparator.
    for (genvar p = 0; p < NSRC; p++) begin : g_pos
        logic x_is_v, y_is_v;
        assign x_is_v = (x_kind[p*KIND_W +: KIND_W] == SRC_VREG);
        assign y_is_v = (y_kind[p*KIND_W +: KIND_W] == SRC_VREG);
        assign pos_conf[p] = x_is_v && y_is_v &&
            (x_src[p*REG_W +: BANK_W] == y_src[p*REG_W +: BANK_W]);
    end

    assign bank_conf = |pos_conf;

    // The bank pair is selected by bit 0 of the destination bank.
    assign dst_clash = (x_dst[0] == y_dst[0]);

endmodule

// File: rtl/dip_scalar_budget.sv
module dip_scalar_budget
    import dip_pkg::*;
#(
    parameter int NSRC       = 2,
    parameter int SCALAR_MAX = 2
) (
    input  logic [NSRC*KIND_W-1:0] x_kind,
    input  logic [NSRC*KIND_W-1:0] y_kind,
    output logic                   over
);

    localparam int NPOS  = 2 * NSRC;
    localparam int CNT_W = $clog2(NPOS + 1);

    logic [NPOS*KIND_W-1:0] all_kind;
    logic [NPOS-1:0]        is_scalar;
    logic [CNT_W-1:0]       used;

    assign all_kind = {y_kind, x_kind};

    // A scalar register and an immediate draw on the same budget.
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        assign is_scalar[p] = (all_kind[p*KIND_W +: KIND_W] == SRC_SREG) ||
                              (all_kind[p*KIND_W +: KIND_W] == SRC_IMM);
    end

    always_comb begin
        used = '0;
        for (int p = 0; p < NPOS; p++) begin
            used = used + CNT_W'(is_scalar[p]);
        end
    end

    assign over = (int'(used) > SCALAR_MAX);

endmodule

// File: rtl/dip_slot_filter.sv
module dip_slot_filter #(
    parameter int                 CLS_W  = 3,
    parameter logic [2**CLS_W-1:0] X_MASK = 8'b0001_1111,
    parameter logic [2**CLS_W-1:0] Y_MASK = 8'b0010_1111
) (
    input  logic [CLS_W-1:0] x_cls,
    input  logic [CLS_W-1:0] y_cls,
    output logic             cls_ok
);

    assign cls_ok = X_MASK[x_cls] && Y_MASK[y_cls];

endmodule

// File: rtl/dip_hazard.sv
module dip_hazard
    import dip_pkg::*;
#(
    parameter int REG_W = 6,
    parameter int NSRC  = 2
) (
    input  logic [NSRC*KIND_W-1:0] x_kind,
    input  logic [NSRC*REG_W-1:0]  x_src,
    input  logic [REG_W-1:0]       x_dst,
    input  logic [REG_W-1:0]       y_dst,
    output logic                   hazard
);

    logic [NSRC-1:0] reads_ydst;

    // A Y result cannot overwrite a register that X still reads.
    for (genvar p = 0; p < NSRC; p++) begin : g_pos
        assign reads_ydst[p] = (x_kind[p*KIND_W +: KIND_W] == SRC_VREG) &&
                               (x_src[p*REG_W +: REG_W] == y_dst);
    end

    assign hazard = (|reads_ydst) || (x_dst == y_dst);

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import dip_pkg::*;
#(
    parameter int REG_W      = 6,
    parameter int NSRC       = 2,
    parameter int CLS_W      = 3,
    parameter int SCALAR_MAX = 2,
    localparam int POS_W     = KIND_W + REG_W,
    localparam int DST_LSB   = NSRC * POS_W,
    localparam int CLS_LSB   = DST_LSB + REG_W,
    localparam int DW        = CLS_LSB + CLS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_x,
    input  logic [DW-1:0] in_y,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_dual,
    output logic          out_x_en,
    output logic          out_y_en,
    output logic [DW-1:0] out_x,
    output logic [DW-1:0] out_y
);

    // Unpack the fields of both incoming descriptors.
    logic [NSRC*KIND_W-1:0] x_kind, y_kind;
    logic [NSRC*REG_W-1:0]  x_src, y_src;
    logic [REG_W-1:0]       x_dst, y_dst;
    logic [CLS_W-1:0]       x_cls, y_cls;

    for (genvar p = 0; p < NSRC; p++) begin : g_unpack
        assign x_kind[p*KIND_W +: KIND_W] = in_x[p*POS_W +: KIND_W];
        assign y_kind[p*KIND_W +: KIND_W] = in_y[p*POS_W +: KIND_W];
        assign x_src[p*REG_W +: REG_W]    = in_x[p*POS_W + KIND_W +: REG_W];
        assign y_src[p*REG_W +: REG_W]    = in_y[p*POS_W + KIND_W +: REG_W];
    end

    assign x_dst = in_x[DST_LSB +: REG_W];
    assign y_dst = in_y[DST_LSB +: REG_W];
    assign x_cls = in_x[CLS_LSB +: CLS_W];
    assign y_cls = in_y[CLS_LSB +: CLS_W];

    // Legality checks.
    logic bank_conf, dst_clash, budget_over, cls_ok, hazard, pair_legal;

    dip_bank_check #(.REG_W(REG_W), .NSRC(NSRC)) u_bank (
        .x_kind(x_kind), .x_src(x_src), .y_kind(y_kind), .y_src(y_src),
        .x_dst(x_dst), .y_dst(y_dst),
        .bank_conf(bank_conf), .dst_clash(dst_clash)
    );

    dip_scalar_budget #(.NSRC(NSRC), .SCALAR_MAX(SCALAR_MAX)) u_budget (
        .x_kind(x_kind), .y_kind(y_kind), .over(budget_over)
    );

    dip_slot_filter #(.CLS_W(CLS_W)) u_slot (
        .x_cls(x_cls), .y_cls(y_cls), .cls_ok(cls_ok)
    );

    dip_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_haz (
        .x_kind(x_kind), .x_src(x_src), .x_dst(x_dst), .y_dst(y_dst),
        .hazard(hazard)
    );

    assign pair_legal = !bank_conf && !dst_clash && !budget_over && cls_ok && !hazard;

    // Issue sequencing.
    issue_st_e cur_st, nxt_st;
    logic      accept, beat_done;

    assign beat_done = out_valid && out_ready;

    always_comb begin
        unique case (cur_st)
            ST_EMPTY: in_ready = 1'b1;
            ST_PAIR:  in_ready = out_ready;
            ST_XONLY: in_ready = 1'b0;
            ST_YONLY: in_ready = out_ready;
            default:  in_ready = 1'b0;
        endcase
    end

    assign accept = in_valid && in_ready;

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            ST_EMPTY: begin
                if (accept) nxt_st = pair_legal ? ST_PAIR : ST_XONLY;
            end
            ST_XONLY: begin
                if (out_ready) nxt_st = ST_YONLY;
            end
            ST_PAIR, ST_YONLY: begin
                if (accept)         nxt_st = pair_legal ? ST_PAIR : ST_XONLY;
                else if (out_ready) nxt_st = ST_EMPTY;
            end
            default: nxt_st = ST_EMPTY;
        endcase
    end

    // State register and descriptor capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_st <= ST_EMPTY;
            out_x  <= '0;
            out_y  <= '0;
        end else begin
            cur_st <= nxt_st;
            if (accept) begin
                out_x <= in_x;
                out_y <= in_y;
            end
        end
    end

    // Output decode.
    always_comb begin
        out_valid = 1'b1;
        out_dual  = 1'b0;
        out_x_en  = 1'b0;
        out_y_en  = 1'b0;
        unique case (cur_st)
            ST_EMPTY: out_valid = 1'b0;
            ST_PAIR: begin
                out_dual = 1'b1;
                out_x_en = 1'b1;
                out_y_en = 1'b1;
            end
            ST_XONLY: out_x_en = 1'b1;
            ST_YONLY: out_y_en = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

    // Assertions.
    a_r2_bank_split: assert property (@(posedge clk) disable iff (!rst_n)
        accept && bank_conf |=> !out_dual);
    a_r3_dst_split: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dst_clash |=> !out_dual);
    a_r4_budget_split: assert property (@(posedge clk) disable iff (!rst_n)
        accept && budget_over |=> !out_dual);
    a_r5_class_split: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cls_ok |=> !out_dual);
    a_r6_hazard_split: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hazard |=> !out_dual);
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid && out_x_en && (out_x == $past(in_x)) && (out_y == $past(in_y)));
    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_x_en && !out_y_en |-> !in_ready);
    a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
        out_x_en && !out_y_en && out_ready |=> out_y_en && !out_x_en && $stable(out_y));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) &&
        $stable(out_dual) && $stable(out_x_en) && $stable(out_y_en));

endmodule

// File: tb/sim_dual_issue_pairer.sv
module sim_dual_issue_pairer;

    localparam int DW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_x = '0;
    logic [DW-1:0] in_y = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_dual, out_x_en, out_y_en;
    logic [DW-1:0] out_x, out_y;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    dual_issue_pairer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
        .out_dual(out_dual), .out_x_en(out_x_en), .out_y_en(out_y_en),
        .out_x(out_x), .out_y(out_y)
    );

    function automatic logic [DW-1:0] mk(input int cls, input int dst,
                                         input int s1, input int k1,
                                         input int s0, input int k0);
        return {cls[2:0], dst[5:0], s1[5:0], k1[1:0], s0[5:0], k0[1:0]};
    endfunction

    // Expected legality, from the requirements.
    function automatic bit exp_legal(input logic [DW-1:0] x, input logic [DW-1:0] y);
        int xk0 = x[1:0];
        int xs0 = x[7:2];
        int xk1 = x[9:8];
        int xs1 = x[15:10];
        int xd  = x[21:16];
        int xc  = x[24:22];
        int yk0 = y[1:0];
        int ys0 = y[7:2];
        int yk1 = y[9:8];
        int ys1 = y[15:10];
        int yd  = y[21:16];
        int yc  = y[24:22];
        int nsc = 0;
        bit ok  = 1'b1;
        if (xk0 == 1 && yk0 == 1 && (xs0 % 4) == (ys0 % 4)) ok = 1'b0;   // R2
        if (xk1 == 1 && yk1 == 1 && (xs1 % 4) == (ys1 % 4)) ok = 1'b0;   // R2
        if ((xd % 2) == (yd % 2)) ok = 1'b0;                             // R3
        nsc = int'(xk0 >= 2) + int'(xk1 >= 2) + int'(yk0 >= 2) + int'(yk1 >= 2);
        if (nsc > 2) ok = 1'b0;                                          // R4
        if (!(xc <= 4)) ok = 1'b0;                                       // R5
        if (!(yc <= 3 || yc == 5)) ok = 1'b0;                            // R5
        if ((xk0 == 1 && xs0 == yd) || (xk1 == 1 && xs1 == yd) || xd == yd) ok = 1'b0; // R6
        return ok;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [DW-1:0] x, input logic [DW-1:0] y,
                        input bit stall, input string tag);
        bit lg = exp_legal(x, y);
        @(negedge clk);
        in_valid = 1'b1; in_x = x; in_y = y; out_ready = 1'b1;
        chk("R8 ready before accept", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " dual grant"}, 64'(out_dual), 64'(lg));
        chk("R7 first beat", {61'd0, out_valid, out_x_en, out_y_en}, {61'd0, 1'b1, 1'b1, lg});
        chk("R7 x descriptor", 64'(out_x), 64'(x));
        if (lg) chk("R7 y descriptor", 64'(out_y), 64'(y));
        if (stall) begin
            out_ready = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk("R9 held beat", {out_valid, out_dual, out_x_en, out_y_en, out_x},
                {1'b1, lg, 1'b1, lg, x});
            chk("R9 no accept while stalled", 64'(in_ready), 64'd0);
            out_ready = 1'b1;
        end
        if (!lg) begin
            chk("R8 gap in ready", 64'(in_ready), 64'd0);
            @(negedge clk);
            chk("R8 second beat", {out_valid, out_dual, out_x_en, out_y_en, out_y},
                {1'b1, 1'b0, 1'b0, 1'b1, y});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {62'd0, out_valid, in_ready}, 64'd1);

        // R2: bank grid at position 0, then position 1; cross positions never conflict.
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                send(mk(0, 2, 0, 0, 16 + a, 1), mk(1, 3, 0, 0, 24 + b, 1), (a == b), "R2");
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                send(mk(0, 2, 16 + a, 1, 0, 0), mk(1, 3, 24 + b, 1, 0, 0), 1'b0, "R2");
        for (int a = 0; a < 4; a++)
            send(mk(0, 2, 0, 0, 16 + a, 1), mk(1, 3, 24 + a, 1, 0, 0), 1'b0, "R2 cross");

        // R3 and R6: destination grid.
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                send(mk(2, 32 + a, 0, 0, 10, 1), mk(3, 32 + b, 0, 0, 11, 1), (a == 3), "R3");

        // R5: every class pairing.
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                send(mk(a, 2, 0, 0, 4, 1), mk(b, 3, 0, 0, 5, 1), 1'b0, "R5");

        // R4: every mix of source kinds.
        for (int m = 0; m < 256; m++)
            send(mk(0, 2, 5, (m >> 2) & 3, 4, m & 3),
                 mk(0, 3, 11, (m >> 6) & 3, 10, (m >> 4) & 3), (m % 17 == 0), "R4");

        // R6: Y destination read by X.
        send(mk(0, 3, 0, 0, 7, 1), mk(0, 7, 0, 0, 8, 1), 1'b0, "R6 src0");
        send(mk(0, 2, 9, 1, 0, 0), mk(0, 9, 0, 0, 8, 1), 1'b0, "R6 src1");
        send(mk(0, 2, 9, 2, 0, 0), mk(0, 9, 0, 0, 8, 1), 1'b0, "R6 scalar ignored");

        // Arbitrary pairs with narrow register numbers.
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] r1 = $urandom;
            logic [31:0] r2 = $urandom;
            send(mk(r1[2:0], r1[6:3], r1[10:7], r1[12:11], r1[16:13], r1[18:17]),
                 mk(r2[2:0], r2[6:3], r2[10:7], r2[12:11], r2[16:13], r2[18:17]),
                 (n % 7 == 0), "R7 mixed");
        end

        @(negedge clk);
        @(negedge clk);
        chk("R1 drained", 64'(out_valid), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule